// File: doc/BRIEF.md
# Received Word Buffer with DMA Write-Out

This block sits between the receive side of a serial command/response bus terminal and a simple local system that has no processor. Each validated data word of an incoming message is pushed into a 32-entry buffer together with a 12-bit mailbox address. The address is built from the command's broadcast flag, its direction bit, its subaddress and the word's position within the message. The buffered words are then written into local memory over a request/grant handshake, using a write strobe, an address bus and a data bus.

Two delivery modes are selected by `burstMode`. In burst mode the block holds every word until the message has been declared good. It then raises one request and, once granted, writes one word every three clocks until the buffer is empty. A message declared bad is discarded before any of it reaches memory. In non-burst mode every buffered word gets its own request and its own three-clock transfer, and the end-of-message indications play no part.

A request that is not granted within `GRANT_WAIT` clocks is abandoned. `hsFail` pulses for one clock and the pending data is dropped: the whole buffer in burst mode, the oldest word in non-burst mode.

Top module: `rx_dma_buffer`

## Requirements
- R1: After reset `busReq`, `memWr` and `hsFail` are all low.
- R2: Each word is written at address {broadcast (bit 11), direction (bit 10), subaddress (bits 9..5), word index (bits 4..0)}. The fields are latched at `msgStart`, and the index restarts at 0 with each `msgStart` and rises by one per received word.
- R3: In burst mode `busReq` stays low while a message is being received and rises only after `msgGood`.
- R4: In burst mode a single granted request writes every buffered word in arrival order, one `memWr` pulse every 3 clocks, with `busReq` held high for the whole burst and dropped after the last word.
- R5: In burst mode `msgBad` empties the buffer. No request and no write follow, and a later message's words are written alone.
- R6: In non-burst mode each word gets its own request. `busReq` falls between words, each transfer takes 3 clocks, and `memWr` is high for one clock per word.
- R7: In non-burst mode `msgGood` and `msgBad` have no effect: the words of a message ended by `msgBad` are still written.
- R8: The buffer holds 32 words, and a word that arrives while it is full is dropped.
- R9: If `busGrant` has not arrived `GRANT_WAIT` (16) clocks after `busReq` rises, `hsFail` pulses for one clock and `busReq` falls. The pending data is dropped: all of it in burst mode, the oldest word in non-burst mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| burstMode | input | 1 | 1 = burst delivery, 0 = per-word delivery |
| msgStart | input | 1 | Strobe: a new message begins; latches the command fields |
| cmdBcast | input | 1 | Command addressed as broadcast |
| cmdTx | input | 1 | Command direction bit |
| cmdSubaddr | input | 5 | Command subaddress |
| wordValid | input | 1 | Strobe: `wordIn` holds a validated data word |
| wordIn | input | 16 | Received data word |
| msgGood | input | 1 | Strobe: the message ended without error |
| msgBad | input | 1 | Strobe: the message ended with an error |
| busReq | output | 1 | Request for the local bus |
| busGrant | input | 1 | Local bus granted |
| memWr | output | 1 | Memory write strobe |
| memAddr | output | 12 | Mailbox address of the word being written |
| memData | output | 16 | Data word being written |
| hsFail | output | 1 | One-clock pulse: grant timed out |

## Verification
The bench targets the point where burst mode must wait. A design that requests on the first word would show a bus request before `msgGood`. A message ended by `msgBad` followed by a good one shows whether a flush leaves stale words behind, which would appear as extra writes with the old subaddress. The 33-word message probes the full boundary, where a missing full check would overwrite word 0 and write the wrong data. The grant-timeout cases in both modes show whether abandoned data is really dropped, since leftover words would be written once grants resume.

// File: rtl/rx_dma_pkg.sv
package rx_dma_pkg;
  typedef struct packed {
    logic pop;    // retire the head word
    logic flush;  // discard every buffered word
  } ctlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2
  } dmaState_t;
endpackage

// File: rtl/rx_dma_path.sv
module rx_dma_path
  import rx_dma_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 5,
  parameter int SA_W   = 5,
  localparam int PW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int AW    = 2 + SA_W + IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msgStart,
  input  logic              cmdBcast,
  input  logic              cmdTx,
  input  logic [SA_W-1:0]   cmdSubaddr,
  input  logic              wordValid,
  input  logic [DATA_W-1:0] wordIn,
  input  ctlStrobes_t       ctl,
  output logic [AW-1:0]     headAddr,
  output logic [DATA_W-1:0] headData,
  output logic [CW-1:0]     fifoCount
);
  logic [DATA_W-1:0] dataMem [DEPTH];
  logic [AW-1:0]     addrMem [DEPTH];
  logic [PW-1:0]     wrPtr, rdPtr;
  logic [IDX_W-1:0]  wordIdx;
  logic              latBcast, latTx;
  logic [SA_W-1:0]   latSa;
  logic              push, isFull;

  assign isFull = (fifoCount == CW'(DEPTH));
  assign push   = wordValid && !isFull && !ctl.flush;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // command fields and word offset for address forming
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latBcast <= 1'b0;
      latTx    <= 1'b0;
      latSa    <= '0;
      wordIdx  <= '0;
    end else if (msgStart) begin
      latBcast <= cmdBcast;
      latTx    <= cmdTx;
      latSa    <= cmdSubaddr;
      wordIdx  <= '0;
    end else if (wordValid) begin
      wordIdx  <= wordIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      dataMem[wrPtr] <= wordIn;
      addrMem[wrPtr] <= {latBcast, latTx, latSa, wordIdx};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
    end else if (ctl.flush) begin
      rdPtr     <= wrPtr;
      fifoCount <= '0;
    end else begin
      if (push)    wrPtr <= nextPtr(wrPtr);
      if (ctl.pop) rdPtr <= nextPtr(rdPtr);
      fifoCount <= fifoCount + CW'(push) - CW'(ctl.pop);
    end
  end

  assign headAddr = addrMem[rdPtr];
  assign headData = dataMem[rdPtr];

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CW'(DEPTH));
  assert_flush_empties_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flush |=> (fifoCount == '0));
endmodule

// File: rtl/rx_dma_ctrl.sv
module rx_dma_ctrl
  import rx_dma_pkg::*;
#(
  parameter int DEPTH      = 32,
  parameter int GRANT_WAIT = 16,
  localparam int CW        = $clog2(DEPTH + 1),
  localparam int WW        = $clog2(GRANT_WAIT + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          burstMode,
  input  logic          msgGood,
  input  logic          msgBad,
  input  logic          busGrant,
  input  logic [CW-1:0] fifoCount,
  output ctlStrobes_t   ctl,
  output logic          busReq,
  output logic          memWr,
  output logic          hsFail
);
  dmaState_t     state;
  logic [1:0]    phase;
  logic [WW-1:0] waitCnt;
  logic          reqExpire, hasData, lastPhase;

  assign hasData   = (fifoCount != '0);
  assign lastPhase = (state == ST_XFER) && (phase == 2'd2);
  assign reqExpire = (state == ST_REQ) && !busGrant && (waitCnt == WW'(GRANT_WAIT - 1));

  always_comb begin
    ctl.pop   = lastPhase || (reqExpire && !burstMode);
    ctl.flush = ((state == ST_IDLE) && burstMode && msgBad) || (reqExpire && burstMode);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      phase   <= '0;
      waitCnt <= '0;
      hsFail  <= 1'b0;
    end else begin
      hsFail <= reqExpire;
      unique case (state)
        ST_IDLE: begin
          waitCnt <= '0;
          if (burstMode ? (msgGood && hasData) : hasData) state <= ST_REQ;
        end
        ST_REQ: begin
          if (busGrant) begin
            state   <= ST_XFER;
            phase   <= '0;
            waitCnt <= '0;
          end else if (reqExpire) begin
            state <= ST_IDLE;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        ST_XFER: begin
          if (phase != 2'd2) begin
            phase <= phase + 1'b1;
          end else begin
            phase <= '0;
            if (!(burstMode && fifoCount > CW'(1))) state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busReq = (state != ST_IDLE);
  assign memWr  = (state == ST_XFER) && (phase == 2'd1);

  assert_wr_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    memWr |=> !memWr);
  assert_wr_under_req_R4: assert property (@(posedge clk) disable iff (!rstN)
    memWr |-> busReq);
  assert_fail_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    hsFail |=> !hsFail);
  assert_fail_drops_req_R9: assert property (@(posedge clk) disable iff (!rstN)
    hsFail |-> !busReq);
  assert_req_after_good_R3: assert property (@(posedge clk) disable iff (!rstN)
    (burstMode && $rose(busReq)) |-> $past(msgGood));
endmodule

// File: rtl/rx_dma_buffer.sv
module rx_dma_buffer
  import rx_dma_pkg::*;
#(
  parameter int DEPTH      = 32,
  parameter int DATA_W     = 16,
  parameter int GRANT_WAIT = 16,
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              burstMode,
  input  logic              msgStart,
  input  logic              cmdBcast,
  input  logic              cmdTx,
  input  logic [4:0]        cmdSubaddr,
  input  logic              wordValid,
  input  logic [DATA_W-1:0] wordIn,
  input  logic              msgGood,
  input  logic              msgBad,
  output logic              busReq,
  input  logic              busGrant,
  output logic              memWr,
  output logic [11:0]       memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              hsFail
);
  ctlStrobes_t   ctl;
  logic [CW-1:0] fifoCount;

  rx_dma_ctrl #(.DEPTH(DEPTH), .GRANT_WAIT(GRANT_WAIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .burstMode(burstMode), .msgGood(msgGood),
    .msgBad(msgBad), .busGrant(busGrant), .fifoCount(fifoCount),
    .ctl(ctl), .busReq(busReq), .memWr(memWr), .hsFail(hsFail)
  );

  rx_dma_path #(.DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(5), .SA_W(5)) u_path (
    .clk(clk), .rstN(rstN), .msgStart(msgStart), .cmdBcast(cmdBcast),
    .cmdTx(cmdTx), .cmdSubaddr(cmdSubaddr), .wordValid(wordValid),
    .wordIn(wordIn), .ctl(ctl), .headAddr(memAddr), .headData(memData),
    .fifoCount(fifoCount)
  );
endmodule

// File: tb/rx_dma_buffer_tb.sv
module rx_dma_buffer_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic burstMode = 1'b1, msgStart = 1'b0, cmdBcast = 1'b0, cmdTx = 1'b0;
  logic [4:0] cmdSubaddr = '0;
  logic wordValid = 1'b0, msgGood = 1'b0, msgBad = 1'b0;
  logic [15:0] wordIn = '0;
  logic busReq, busGrant = 1'b0, memWr, hsFail;
  logic [11:0] memAddr;
  logic [15:0] memData;

  int checks = 0, failures = 0, cyc = 0;
  logic grantEn = 1'b1, clrLog = 1'b0, reqPrev = 1'b0;
  logic [11:0] logAddr [64];
  logic [15:0] logData [64];
  int logCyc [64];
  int logN = 0, reqRises = 0, failPulses = 0;

  always #2 clk = ~clk;

  rx_dma_buffer u_dut (
    .clk(clk), .rstN(rstN), .burstMode(burstMode), .msgStart(msgStart),
    .cmdBcast(cmdBcast), .cmdTx(cmdTx), .cmdSubaddr(cmdSubaddr),
    .wordValid(wordValid), .wordIn(wordIn), .msgGood(msgGood), .msgBad(msgBad),
    .busReq(busReq), .busGrant(busGrant), .memWr(memWr), .memAddr(memAddr),
    .memData(memData), .hsFail(hsFail)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // observer: samples outputs on the falling edge, plays the granting system
  always @(negedge clk) begin
    if (clrLog) begin
      logN = 0; reqRises = 0; failPulses = 0;
    end else begin
      if (memWr && logN < 64) begin
        logAddr[logN] = memAddr; logData[logN] = memData; logCyc[logN] = cyc;
        logN++;
      end
      if (busReq && !reqPrev) reqRises++;
      if (hsFail) failPulses++;
    end
    reqPrev  = busReq;
    busGrant = busReq & grantEn;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic clearLog();
    clrLog = 1'b1; tick(1); clrLog = 1'b0;
  endtask

  task automatic startMsg(input bit bc, input bit tx, input logic [4:0] sa);
    cmdBcast = bc; cmdTx = tx; cmdSubaddr = sa; msgStart = 1'b1;
    tick(1); msgStart = 1'b0; tick(1);
  endtask

  task automatic sendWords(input int n, input logic [15:0] base);
    for (int i = 0; i < n; i++) begin
      wordIn = base + 16'(i); wordValid = 1'b1; tick(1);
      wordValid = 1'b0; tick(1);
    end
  endtask

  task automatic endMsg(input bit good);
    if (good) msgGood = 1'b1; else msgBad = 1'b1;
    tick(1); msgGood = 1'b0; msgBad = 1'b0; tick(1);
  endtask

  function automatic int mkAddr(input bit bc, input bit tx, input int sa, input int idx);
    return (int'(bc) << 11) | (int'(tx) << 10) | (sa << 5) | idx;
  endfunction

  task automatic checkLog(input string req, input int n, input bit bc, input bit tx,
                          input int sa, input logic [15:0] base);
    check(logN == n, req, logN, n);
    for (int i = 0; i < n && i < logN; i++) begin
      check(int'(logAddr[i]) == mkAddr(bc, tx, sa, i), req, logAddr[i], mkAddr(bc, tx, sa, i));
      check(logData[i] == base + 16'(i), req, logData[i], base + 16'(i));
    end
  endtask

  task automatic testReset();
    check(busReq == 1'b0, "R1 busReq", busReq, 0);
    check(memWr == 1'b0, "R1 memWr", memWr, 0);
    check(hsFail == 1'b0, "R1 hsFail", hsFail, 0);
  endtask

  task automatic testBurstGood();
    burstMode = 1'b1; clearLog();
    startMsg(1'b0, 1'b0, 5'd5); sendWords(4, 16'hA000); tick(6);
    check(reqRises == 0, "R3 no request before good", reqRises, 0);
    endMsg(1'b1); tick(30);
    check(reqRises == 1, "R4 single request", reqRises, 1);
    checkLog("R2 R4 burst addr/data", 4, 1'b0, 1'b0, 5, 16'hA000);
    for (int i = 1; i < logN; i++)
      check(logCyc[i] - logCyc[i-1] == 3, "R4 spacing", logCyc[i] - logCyc[i-1], 3);
    check(busReq == 1'b0, "R4 request dropped", busReq, 0);
  endtask

  task automatic testBurstBad();
    burstMode = 1'b1; clearLog();
    startMsg(1'b0, 1'b0, 5'd7); sendWords(3, 16'hB000); endMsg(1'b0); tick(20);
    check(reqRises == 0, "R5 no request after bad", reqRises, 0);
    check(logN == 0, "R5 no writes after bad", logN, 0);
    startMsg(1'b1, 1'b0, 5'd2); sendWords(2, 16'hC000); endMsg(1'b1); tick(20);
    checkLog("R5 R2 next message alone", 2, 1'b1, 1'b0, 2, 16'hC000);
  endtask

  task automatic testNonBurst();
    burstMode = 1'b0; clearLog();
    startMsg(1'b0, 1'b1, 5'd3); sendWords(3, 16'hD000); endMsg(1'b0); tick(40);
    check(reqRises == 3, "R6 one request per word", reqRises, 3);
    checkLog("R7 R2 words kept despite bad", 3, 1'b0, 1'b1, 3, 16'hD000);
    for (int i = 1; i < logN; i++)
      check(logCyc[i] - logCyc[i-1] >= 4, "R6 request gap", logCyc[i] - logCyc[i-1], 4);
    burstMode = 1'b1;
  endtask

  task automatic testOverflow();
    burstMode = 1'b1; clearLog();
    startMsg(1'b0, 1'b0, 5'd9); sendWords(33, 16'h1000); endMsg(1'b1); tick(130);
    checkLog("R8 only 32 words kept", 32, 1'b0, 1'b0, 9, 16'h1000);
  endtask

  task automatic testTimeout();
    burstMode = 1'b1; grantEn = 1'b0; clearLog();
    startMsg(1'b0, 1'b0, 5'd4); sendWords(4, 16'h2000); endMsg(1'b1); tick(40);
    check(failPulses == 1, "R9 burst hsFail pulse", failPulses, 1);
    check(busReq == 1'b0, "R9 burst request dropped", busReq, 0);
    grantEn = 1'b1; clearLog();
    startMsg(1'b0, 1'b0, 5'd6); sendWords(2, 16'h3000); endMsg(1'b1); tick(20);
    checkLog("R9 burst data discarded", 2, 1'b0, 1'b0, 6, 16'h3000);
    burstMode = 1'b0; grantEn = 1'b0; clearLog();
    startMsg(1'b0, 1'b1, 5'd1); sendWords(1, 16'h4000); tick(40);
    check(failPulses == 1, "R9 non-burst hsFail pulse", failPulses, 1);
    grantEn = 1'b1; clearLog();
    startMsg(1'b0, 1'b1, 5'd1); sendWords(1, 16'h5000); tick(20);
    checkLog("R9 non-burst head dropped", 1, 1'b0, 1'b1, 1, 16'h5000);
    burstMode = 1'b1;
  endtask

  initial begin : watchdog
    #(4 * 100000);
    failures++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(3);
    testReset();
    rstN = 1'b1; tick(2);
    testReset();
    testBurstGood();
    testBurstBad();
    testNonBurst();
    testOverflow();
    testTimeout();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule